// File: doc/BRIEF.md
# Saturating Coin Total Display

The block accumulates coins from a single push button. Every press adds one 25-cent coin to a running total, and the total stops at one dollar. The raw button and a clear button both pass through a two-stage synchroniser. Only the rising edge of the synchronised button advances the count, so a press held for any length of time adds exactly one coin.

The current count drives two seven-segment digits. The digits read 00, 25, 50 and 75 for zero to three coins. When the total reaches one dollar they switch to dollar form and read 10. The internal press count is also brought out as a port.

All flops take an active-low asynchronous reset. The clear button acts as a synchronous, active-high clear of the count once it has crossed its own synchroniser.

Top module: `coin_total_display`

## Requirements
- R1: After the asynchronous reset the press count is 0 and both digits show 0 (pattern 8'hC0).
- R2: A rising edge on the button raises the press count by one. The new count appears after the third rising clock edge that samples the button high.
- R3: A press held for many cycles adds exactly one to the count.
- R4: The press count never exceeds 4. Further presses at 4 leave the count and the display unchanged.
- R5: Segment outputs are active low with bit order {dp,g,f,e,d,c,b,a}. The digit codes are 0=C0, 1=F9, 2=A4, 5=92 and 7=F8. The left/right pairs show 0-0, 2-5, 5-0, 7-5 and 1-0 for counts 0 to 4.
- R6: The decimal point (bit 7) of both digits is always high, which means off.
- R7: Asserting the clear input returns the count to 0 after the third rising clock edge that samples it high.
- R8: When a clear and a button press arrive in the same cycle, the clear wins and the count ends at 0.
- R9: Releasing the button (a falling edge) does not change the count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| btn_i | input | 1 | Raw coin button, active high |
| clr_i | input | 1 | Raw clear button, active high |
| seg_left_o | output | 8 | Left digit segments, active low |
| seg_right_o | output | 8 | Right digit segments, active low |
| press_cnt_o | output | 3 | Number of coins counted |

## Verification
The bench builds the block with its default parameters: two synchroniser stages, a limit of four presses and 25 cents per press. With these values the total passes the dollar boundary, so the switch from cents form to dollar form on the display is exercised, and saturation is reached within a handful of presses. The three-cycle latency of both the button path and the clear path is checked cycle by cycle against a behavioural model. The case where a clear and a press arrive together is also driven.

// File: rtl/coin_disp_pkg.sv
package coin_disp_pkg;
  typedef logic [7:0] seg_t;

  // active-low {dp,g,f,e,d,c,b,a}, dp held off
  function automatic seg_t seg_of_digit(input logic [3:0] d);
    logic [6:0] on;
    case (d)
      4'd0: on = 7'h3F;
      4'd1: on = 7'h06;
      4'd2: on = 7'h5B;
      4'd3: on = 7'h4F;
      4'd4: on = 7'h66;
      4'd5: on = 7'h6D;
      4'd6: on = 7'h7D;
      4'd7: on = 7'h07;
      4'd8: on = 7'h7F;
      4'd9: on = 7'h6F;
      default: on = 7'h00;
    endcase
    return {1'b1, ~on};
  endfunction
endpackage

// File: rtl/coin_sync.sv
module coin_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] stage_q;

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stage_q[i] <= 1'b0;
      else         stage_q[i] <= (i == 0) ? d_i : stage_q[(i == 0) ? 0 : i-1];
    end
  end

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/coin_edge.sv
module coin_edge (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic lvl_i,
  output logic rise_o
);
  logic prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= 1'b0;
    else         prev_q <= lvl_i;
  end

  assign rise_o = lvl_i & ~prev_q;
endmodule

// File: rtl/coin_sat_cnt.sv
module coin_sat_cnt #(
  parameter int MAX_PRESSES = 4,
  parameter int CNT_W       = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             inc_i,
  output logic [CNT_W-1:0] cnt_o
);
  localparam logic [CNT_W-1:0] MaxV = CNT_W'(MAX_PRESSES);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                      cnt_q <= '0;
    else if (clr_i)                   cnt_q <= '0;  // clear beats a press
    else if (inc_i && cnt_q != MaxV)  cnt_q <= cnt_q + CNT_W'(1);
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/coin_digit_decode.sv
module coin_digit_decode
  import coin_disp_pkg::*;
#(
  parameter int STEP_CENTS = 25,
  parameter int CNT_W      = 3
) (
  input  logic [CNT_W-1:0] cnt_i,
  output seg_t             seg_hi_o,
  output seg_t             seg_lo_o
);
  int cents;
  int hi_d;
  int lo_d;

  always_comb begin
    cents = int'(cnt_i) * STEP_CENTS;
    if (cents >= 100) begin
      // dollar form: whole dollars then tenths
      hi_d = (cents / 100) % 10;
      lo_d = (cents / 10) % 10;
    end else begin
      hi_d = cents / 10;
      lo_d = cents % 10;
    end
  end

  assign seg_hi_o = seg_of_digit(4'(hi_d));
  assign seg_lo_o = seg_of_digit(4'(lo_d));
endmodule

// File: rtl/coin_total_display.sv
module coin_total_display
  import coin_disp_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int MAX_PRESSES = 4,
  parameter int STEP_CENTS  = 25
) (
  input  logic                               clk_i,
  input  logic                               rst_ni,
  input  logic                               btn_i,
  input  logic                               clr_i,
  output logic [7:0]                         seg_left_o,
  output logic [7:0]                         seg_right_o,
  output logic [$clog2(MAX_PRESSES+1)-1:0]   press_cnt_o
);
  localparam int CNT_W = $clog2(MAX_PRESSES+1);

  logic             btn_sync;
  logic             clr_sync;
  logic             press_pulse;
  logic [CNT_W-1:0] cnt;
  seg_t             seg_hi;
  seg_t             seg_lo;

  coin_sync #(.STAGES(SYNC_STAGES)) u_btn_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(btn_i), .q_o(btn_sync)
  );

  coin_sync #(.STAGES(SYNC_STAGES)) u_clr_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(clr_i), .q_o(clr_sync)
  );

  coin_edge u_edge (
    .clk_i(clk_i), .rst_ni(rst_ni), .lvl_i(btn_sync), .rise_o(press_pulse)
  );

  coin_sat_cnt #(.MAX_PRESSES(MAX_PRESSES), .CNT_W(CNT_W)) u_cnt (
    .clk_i(clk_i), .rst_ni(rst_ni), .clr_i(clr_sync),
    .inc_i(press_pulse), .cnt_o(cnt)
  );

  coin_digit_decode #(.STEP_CENTS(STEP_CENTS), .CNT_W(CNT_W)) u_dec (
    .cnt_i(cnt), .seg_hi_o(seg_hi), .seg_lo_o(seg_lo)
  );

  assign seg_left_o  = seg_hi;
  assign seg_right_o = seg_lo;
  assign press_cnt_o = cnt;
endmodule

// File: rtl/coin_total_display_chk.sv
module coin_total_display_chk #(
  parameter int MAX_PRESSES = 4,
  parameter int CNT_W       = 3
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             pulse_i,
  input logic             clr_i,
  input logic [CNT_W-1:0] cnt_i,
  input logic [7:0]       seg_l_i,
  input logic [7:0]       seg_r_i
);
  localparam logic [CNT_W-1:0] MaxV = CNT_W'(MAX_PRESSES);

  assert_bound_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_i <= MaxV);

  assert_hold_max_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_i == MaxV && !clr_i) |=> cnt_i == MaxV);

  assert_inc_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pulse_i && !clr_i && cnt_i != MaxV) |=> cnt_i == $past(cnt_i) + CNT_W'(1));

  assert_single_pulse_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pulse_i |=> !pulse_i);

  assert_no_pulse_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!pulse_i && !clr_i) |=> cnt_i == $past(cnt_i));

  assert_clear_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> cnt_i == '0);

  assert_dp_off_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    seg_l_i[7] && seg_r_i[7]);

  assert_zero_disp_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_i == '0 |-> (seg_l_i == 8'hC0 && seg_r_i == 8'hC0));
endmodule

bind coin_total_display coin_total_display_chk #(
  .MAX_PRESSES(MAX_PRESSES), .CNT_W(CNT_W)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .pulse_i(press_pulse), .clr_i(clr_sync),
  .cnt_i(cnt), .seg_l_i(seg_left_o), .seg_r_i(seg_right_o)
);

// File: tb/sim_coin_total_display.sv
`timescale 1ns/1ps
module sim_coin_total_display;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       btn = 1'b0;
  logic       clr = 1'b0;
  logic [7:0] seg_l, seg_r;
  logic [2:0] cnt;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  always #5 clk = ~clk;

  coin_total_display u0 (
    .clk_i(clk), .rst_ni(rst_n), .btn_i(btn), .clr_i(clr),
    .seg_left_o(seg_l), .seg_right_o(seg_r), .press_cnt_o(cnt)
  );

  // behavioural reference: two-deep input histories, edge on delayed level
  int m_cnt;
  bit bh[2];
  bit ch[2];
  bit m_prev;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cnt = 0; bh[0] = 0; bh[1] = 0; ch[0] = 0; ch[1] = 0; m_prev = 0;
    end else begin
      if (ch[1])                      m_cnt = 0;
      else if (bh[1] && !m_prev && m_cnt < 4) m_cnt = m_cnt + 1;
      m_prev = bh[1];
      bh[1] = bh[0]; bh[0] = btn;
      ch[1] = ch[0]; ch[0] = clr;
    end
  end

  function automatic logic [15:0] exp_disp(input int c);
    case (c)
      0: return {8'hC0, 8'hC0};
      1: return {8'hA4, 8'h92};
      2: return {8'h92, 8'hC0};
      3: return {8'hF8, 8'h92};
      default: return {8'hF9, 8'hC0};
    endcase
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", tag, act, exp, $time);
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk(int'(cnt) == m_cnt, "R2 count vs model", cnt, m_cnt);
      chk({seg_l, seg_r} == exp_disp(m_cnt), "R5 display vs model", {seg_l, seg_r}, exp_disp(m_cnt));
    end
  end

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic press(input int hold);
    btn = 1'b1; tick(hold); btn = 1'b0; tick(4);
  endtask

  initial begin
    int base;
    tick(3);
    // R1 reset state
    chk(cnt == 3'd0, "R1 count after reset", cnt, 0);
    chk(seg_l == 8'hC0 && seg_r == 8'hC0, "R1 display after reset", {seg_l, seg_r}, 16'hC0C0);
    rst_n = 1'b1;
    tick(3);

    // R2 latency: count moves on third edge
    btn = 1'b1;
    tick(2);
    chk(cnt == 3'd0, "R2 not yet after two edges", cnt, 0);
    tick(1);
    chk(cnt == 3'd1, "R2 counted after third edge", cnt, 1);
    chk(seg_l == 8'hA4 && seg_r == 8'h92, "R5 shows 25", {seg_l, seg_r}, 16'hA492);

    // R3 long hold adds one
    tick(30);
    chk(cnt == 3'd1, "R3 long hold counts once", cnt, 1);

    // R9 release has no effect
    btn = 1'b0;
    tick(6);
    chk(cnt == 3'd1, "R9 release ignored", cnt, 1);

    press(1);
    chk(cnt == 3'd2 && seg_l == 8'h92 && seg_r == 8'hC0, "R5 shows 50", {seg_l, seg_r}, 16'h92C0);
    press(2);
    chk(cnt == 3'd3 && seg_l == 8'hF8 && seg_r == 8'h92, "R5 shows 75", {seg_l, seg_r}, 16'hF892);
    press(3);
    chk(cnt == 3'd4 && seg_l == 8'hF9 && seg_r == 8'hC0, "R5 shows 10", {seg_l, seg_r}, 16'hF9C0);

    // R4 saturation
    for (int k = 0; k < 5; k++) press(2);
    chk(cnt == 3'd4, "R4 saturated count", cnt, 4);
    chk(seg_l == 8'hF9 && seg_r == 8'hC0, "R4 display held", {seg_l, seg_r}, 16'hF9C0);
    chk(seg_l[7] && seg_r[7], "R6 dp off", {seg_l[7], seg_r[7]}, 3);

    // R7 clear latency
    clr = 1'b1;
    tick(2);
    chk(cnt == 3'd4, "R7 clear not yet", cnt, 4);
    tick(1);
    chk(cnt == 3'd0, "R7 cleared on third edge", cnt, 0);
    clr = 1'b0;
    tick(4);
    chk(seg_l == 8'hC0 && seg_r == 8'hC0, "R5 shows 00", {seg_l, seg_r}, 16'hC0C0);

    // R8 clear and press together
    press(1);
    base = int'(cnt);
    chk(base == 1, "R8 setup count", base, 1);
    clr = 1'b1; btn = 1'b1;
    tick(3);
    clr = 1'b0;
    tick(5);
    chk(cnt == 3'd0, "R8 clear wins over press", cnt, 0);
    btn = 1'b0;
    tick(5);
    chk(cnt == 3'd0, "R8 no late count", cnt, 0);

    // mixed pattern against the model
    for (int k = 0; k < 40; k++) begin
      btn = ((k * 7) % 5) < 2;
      clr = (k % 17) == 16;
      tick(1 + (k % 3));
    end
    btn = 1'b0; clr = 1'b0;
    tick(6);
    chk(seg_l[7] && seg_r[7], "R6 dp off after mix", {seg_l[7], seg_r[7]}, 3);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #1_000_000;
    if (!done) begin
      done = 1'b1;
      total++; bad++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule